// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block holds the configuration-space state that places two I/O windows of a power-management PCI function: a 128-byte window for the power-management register file and a 16-byte window for the SMBus host controller. Software programs a base address for each window through 32-bit configuration writes that carry a byte-enable mask. The block merges the enabled bytes into the stored value, then clears the address bits below the window size and forces bit 0 high to mark the register as I/O space. Each window also has an enable bit. These enable bits live in separate configuration bytes, away from the base registers.

On the I/O side, the block compares every presented I/O address with both windows. One cycle later it reports a registered hit and the offset inside the matching window. Accesses to the power-management window are byte-wide only. A wider access there produces no hit. Configuration reads return the normalised register values one cycle after the request.

Top module: `pmio_base_decoder`

## Requirements
- R1: After synchronous reset, dword 0x48 and dword 0x90 read 0x00000001, dwords 0x40 and 0xD0 read 0x00000000, and neither hit output is set.
- R2: A write that hits dword 0x48 leaves that register at (merged value AND 0x0000FF80) OR 1.
- R3: A write that hits dword 0x90 leaves that register at (merged value AND 0x0000FFF0) OR 1.
- R4: Byte lane i (bits 8i+7:8i) of a configuration write takes effect only when `cfg_be[i]` is 1. Disabled lanes keep the stored byte, and masking is applied after the merge.
- R5: Bit 15 of dword 0x40 (bit 7 of byte 0x41) is the power-management window enable and can be read back. Every other bit of that dword reads 0.
- R6: Bits 19:16 of dword 0xD0 (bits 3:0 of byte 0xD2) are writable and can be read back. Bits 23:20 and all other bits read 0. Bit 16 is the SMBus window enable.
- R7: An I/O access with `io_size` = 00 (byte) whose address bits 15:7 equal the power-management base bits 15:7, made while that window is enabled, sets `pm_hit` in the next cycle with `pm_off` equal to address bits 6:0.
- R8: A power-management window access with `io_size` 01 (word) or 10 (dword) does not set `pm_hit`.
- R9: An I/O access of any size whose address bits 15:4 equal the SMBus base bits 15:4, made while that window is enabled, sets `smb_hit` in the next cycle with `smb_off` equal to address bits 3:0. A disabled window never hits.
- R10: An I/O access presented in the same cycle as a configuration write is decoded with the old settings. An access in the following cycle uses the new settings.
- R11: `cfg_rdata` is valid in the cycle after `cfg_rd`. Dwords other than 0x40, 0x48, 0x90 and 0xD0 read 0. The offset outputs read 0 whenever their hit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte address (bits 7:2 select the dword) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_valid | input | 1 | I/O access presented |
| io_addr | input | 16 | I/O address |
| io_size | input | 2 | Access width: 00 byte, 01 word, 10 dword |
| pm_hit | output | 1 | Registered power-management window hit |
| pm_off | output | 7 | Offset inside the power-management window |
| smb_hit | output | 1 | Registered SMBus window hit |
| smb_off | output | 4 | Offset inside the SMBus window |

## Verification
A base register that is stored wrongly has two visible effects. The next readback of dword 0x48 or 0x90 is wrong, and an I/O access one cycle after the write hits or misses at the wrong address. Addresses are therefore probed on both sides of each window edge. A lost or stuck enable flips `pm_hit` or `smb_hit` on the very next access. A fault in lane merging only shows after a partial write followed by a read, so several partial writes are read back in sequence.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
  localparam int IO_ADDR_W   = 16;
  localparam int CFG_DW_W    = 6;
  localparam logic [CFG_DW_W-1:0] DW_PM_EN   = 6'h10; // byte 0x40
  localparam logic [CFG_DW_W-1:0] DW_PM_BASE = 6'h12; // byte 0x48
  localparam logic [CFG_DW_W-1:0] DW_SMB_BS  = 6'h24; // byte 0x90
  localparam logic [CFG_DW_W-1:0] DW_SMB_EN  = 6'h34; // byte 0xD0

  typedef enum logic [1:0] {
    IO_BYTE  = 2'b00,
    IO_WORD  = 2'b01,
    IO_DWORD = 2'b10
  } io_size_e;

  function automatic logic [31:0] merge_lanes(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? wd[8*i +: 8] : cur[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pmio_cfg_regs.sv
module pmio_cfg_regs
  import pmio_pkg::*;
#(
  parameter int ADDR_W   = IO_ADDR_W,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [CFG_DW_W-1:0]      dw,
  input  logic [3:0]               be,
  input  logic [31:0]              wdata,
  output logic [ADDR_W-1:PM_LOG2]  pm_base,
  output logic [ADDR_W-1:SMB_LOG2] smb_base,
  output logic                     pm_en,
  output logic [3:0]               smb_ctl
);
  logic [31:0] pm_cur, smb_cur, pm_mrg, smb_mrg;

  // Current register images, bit 0 high as stored form
  assign pm_cur  = 32'({pm_base, {PM_LOG2{1'b0}}}) | 32'd1;
  assign smb_cur = 32'({smb_base, {SMB_LOG2{1'b0}}}) | 32'd1;
  assign pm_mrg  = merge_lanes(pm_cur, wdata, be);
  assign smb_mrg = merge_lanes(smb_cur, wdata, be);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_base  <= '0;
      smb_base <= '0;
      pm_en    <= 1'b0;
      smb_ctl  <= 4'h0;
    end else if (wr) begin
      if (dw == DW_PM_BASE) pm_base  <= pm_mrg[ADDR_W-1:PM_LOG2];
      if (dw == DW_SMB_BS)  smb_base <= smb_mrg[ADDR_W-1:SMB_LOG2];
      if (dw == DW_PM_EN && be[1])  pm_en   <= wdata[15];
      if (dw == DW_SMB_EN && be[2]) smb_ctl <= wdata[19:16];
    end
  end
endmodule

// File: rtl/pmio_win_decode.sv
module pmio_win_decode #(
  parameter int ADDR_W    = 16,
  parameter int WIN_LOG2  = 7,
  parameter bit BYTE_ONLY = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               size,
  input  logic [ADDR_W-1:WIN_LOG2] base,
  input  logic                     en,
  output logic                     hit,
  output logic [WIN_LOG2-1:0]      off
);
  logic size_ok, match;

  generate
    if (BYTE_ONLY) begin : g_byte
      assign size_ok = (size == 2'b00);
    end else begin : g_any
      assign size_ok = 1'b1;
    end
  endgenerate

  assign match = valid && en && size_ok && (addr[ADDR_W-1:WIN_LOG2] == base);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      off <= '0;
    end else begin
      hit <= match;
      off <= match ? addr[WIN_LOG2-1:0] : '0;
    end
  end
endmodule

// File: rtl/pmio_cfg_read.sv
module pmio_cfg_read
  import pmio_pkg::*;
#(
  parameter int ADDR_W   = IO_ADDR_W,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd,
  input  logic [CFG_DW_W-1:0]      dw,
  input  logic [ADDR_W-1:PM_LOG2]  pm_base,
  input  logic [ADDR_W-1:SMB_LOG2] smb_base,
  input  logic                     pm_en,
  input  logic [3:0]               smb_ctl,
  output logic [31:0]              rdata
);
  logic [31:0] sel;

  always_comb begin
    unique case (dw)
      DW_PM_EN:   sel = {16'h0, pm_en, 15'h0};
      DW_PM_BASE: sel = 32'({pm_base, {PM_LOG2{1'b0}}}) | 32'd1;
      DW_SMB_BS:  sel = 32'({smb_base, {SMB_LOG2{1'b0}}}) | 32'd1;
      DW_SMB_EN:  sel = {12'h0, smb_ctl, 16'h0};
      default:    sel = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 32'h0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/pmio_base_decoder.sv
module pmio_base_decoder
  import pmio_pkg::*;
#(
  parameter int ADDR_W   = IO_ADDR_W,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [7:0]          cfg_addr,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                io_valid,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [1:0]          io_size,
  output logic                pm_hit,
  output logic [PM_LOG2-1:0]  pm_off,
  output logic                smb_hit,
  output logic [SMB_LOG2-1:0] smb_off
);
  logic [CFG_DW_W-1:0]      dw;
  logic [ADDR_W-1:PM_LOG2]  pm_base;
  logic [ADDR_W-1:SMB_LOG2] smb_base;
  logic                     pm_en;
  logic [3:0]               smb_ctl;

  assign dw = cfg_addr[7:2];

  pmio_cfg_regs #(.ADDR_W(ADDR_W), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .dw(dw), .be(cfg_be), .wdata(cfg_wdata),
    .pm_base(pm_base), .smb_base(smb_base), .pm_en(pm_en), .smb_ctl(smb_ctl)
  );

  pmio_cfg_read #(.ADDR_W(ADDR_W), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2)) u_read (
    .clk(clk), .rst(rst), .rd(cfg_rd), .dw(dw), .pm_base(pm_base),
    .smb_base(smb_base), .pm_en(pm_en), .smb_ctl(smb_ctl), .rdata(cfg_rdata)
  );

  pmio_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(PM_LOG2), .BYTE_ONLY(1'b1)) u_pm_win (
    .clk(clk), .rst(rst), .valid(io_valid), .addr(io_addr), .size(io_size),
    .base(pm_base), .en(pm_en), .hit(pm_hit), .off(pm_off)
  );

  pmio_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(SMB_LOG2), .BYTE_ONLY(1'b0)) u_smb_win (
    .clk(clk), .rst(rst), .valid(io_valid), .addr(io_addr), .size(io_size),
    .base(smb_base), .en(smb_ctl[0]), .hit(smb_hit), .off(smb_off)
  );
endmodule

// File: rtl/pmio_base_decoder_chk.sv
module pmio_base_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int PM_LOG2  = 7,
  parameter int SMB_LOG2 = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_rd,
  input logic [7:0]          cfg_addr,
  input logic [31:0]         cfg_rdata,
  input logic                io_valid,
  input logic [ADDR_W-1:0]   io_addr,
  input logic [1:0]          io_size,
  input logic                pm_hit,
  input logic [PM_LOG2-1:0]  pm_off,
  input logic                smb_hit,
  input logic [SMB_LOG2-1:0] smb_off
);
  assert_pm_byte_only_R8: assert property (@(posedge clk) disable iff (rst)
    pm_hit |-> $past(io_valid && io_size == 2'b00));

  assert_pm_offset_R7: assert property (@(posedge clk) disable iff (rst)
    pm_hit |-> pm_off == $past(io_addr[PM_LOG2-1:0]));

  assert_smb_offset_R9: assert property (@(posedge clk) disable iff (rst)
    smb_hit |-> (smb_off == $past(io_addr[SMB_LOG2-1:0])) && $past(io_valid));

  assert_pm_base_form_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr[7:2] == 6'h12) |=>
      (cfg_rdata[0] && cfg_rdata[6:1] == 6'h0 && cfg_rdata[31:16] == 16'h0));

  assert_smb_base_form_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr[7:2] == 6'h24) |=>
      (cfg_rdata[0] && cfg_rdata[3:1] == 3'h0 && cfg_rdata[31:16] == 16'h0));

  assert_smb_ctl_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr[7:2] == 6'h34) |=> cfg_rdata[23:20] == 4'h0);

  assert_off_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!pm_hit |-> pm_off == '0) and (!smb_hit |-> smb_off == '0));
endmodule

bind pmio_base_decoder pmio_base_decoder_chk #(
  .ADDR_W(ADDR_W), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .io_valid(io_valid), .io_addr(io_addr), .io_size(io_size),
  .pm_hit(pm_hit), .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off)
);

// File: tb/tb_pmio_base_decoder.sv
`timescale 1ns/1ps
module tb_pmio_base_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        pm_hit, smb_hit;
  logic [6:0]  pm_off;
  logic [3:0]  smb_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmio_base_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_valid(io_valid), .io_addr(io_addr), .io_size(io_size),
    .pm_hit(pm_hit), .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic io_check(input string tag, input logic [15:0] a, input logic [1:0] sz,
                          input logic exp_pm, input logic [6:0] exp_pmo,
                          input logic exp_smb, input logic [3:0] exp_smbo);
    io_valid = 1'b1; io_addr = a; io_size = sz;
    @(negedge clk);
    io_valid = 1'b0;
    chk({tag, " pm"}, {24'h0, pm_hit, pm_off}, {24'h0, exp_pm, exp_pmo});
    chk({tag, " smb"}, {27'h0, smb_hit, smb_off}, {27'h0, exp_smb, exp_smbo});
  endtask

  task automatic t_reset;
    chk("R1 hits idle", {30'h0, pm_hit, smb_hit}, 32'h0);
    cfg_check("R1 pm base", 8'h48, 32'h0000_0001);
    cfg_check("R1 smb base", 8'h90, 32'h0000_0001);
    cfg_check("R1 pm enable", 8'h40, 32'h0);
    cfg_check("R1 smb ctl", 8'hD0, 32'h0);
  endtask

  task automatic t_bases;
    cfg_write(8'h48, 32'h1234_5678, 4'hF);
    cfg_check("R2 pm base mask", 8'h48, 32'h0000_5601);
    cfg_write(8'h90, 32'hABCD_EF57, 4'hF);
    cfg_check("R3 smb base mask", 8'h90, 32'h0000_EF51);
    cfg_check("R11 undefined dword", 8'h80, 32'h0);
  endtask

  task automatic t_lanes;
    cfg_write(8'h48, 32'h0000_FFFF, 4'b0001);
    cfg_check("R4 low lane only", 8'h48, 32'h0000_5681);
    cfg_write(8'h48, 32'h0000_1200, 4'b0010);
    cfg_check("R4 lane one only", 8'h48, 32'h0000_1281);
    cfg_write(8'h48, 32'hFFFF_0000, 4'b1100);
    cfg_check("R4 upper lanes no effect", 8'h48, 32'h0000_1281);
  endtask

  task automatic t_enables;
    cfg_write(8'h40, 32'hFFFF_FFFF, 4'b0010);
    cfg_check("R5 pm enable set", 8'h40, 32'h0000_8000);
    cfg_write(8'hD0, 32'hFFFF_FFFF, 4'b0100);
    cfg_check("R6 smb ctl upper zero", 8'hD0, 32'h000F_0000);
    cfg_write(8'hD0, 32'h00FE_0000, 4'b1011);
    cfg_check("R6 smb ctl lane disabled", 8'hD0, 32'h000F_0000);
  endtask

  task automatic t_pm_decode;
    io_check("R7 pm hit", 16'h12C5, 2'b00, 1'b1, 7'h45, 1'b0, 4'h0);
    io_check("R7 pm base edge", 16'h1280, 2'b00, 1'b1, 7'h00, 1'b0, 4'h0);
    io_check("R7 pm above window", 16'h1300, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
    io_check("R7 pm below window", 16'h127F, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
    io_check("R8 pm word", 16'h1285, 2'b01, 1'b0, 7'h0, 1'b0, 4'h0);
    io_check("R8 pm dword", 16'h1284, 2'b10, 1'b0, 7'h0, 1'b0, 4'h0);
    cfg_write(8'h40, 32'h0, 4'b0010);
    io_check("R7 pm disabled", 16'h12C5, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
    cfg_write(8'h40, 32'h0000_8000, 4'b0010);
  endtask

  task automatic t_smb_decode;
    io_check("R9 smb hit dword", 16'hEF5A, 2'b10, 1'b0, 7'h0, 1'b1, 4'hA);
    io_check("R9 smb last byte", 16'hEF5F, 2'b00, 1'b0, 7'h0, 1'b1, 4'hF);
    io_check("R9 smb above", 16'hEF60, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
    cfg_write(8'hD0, 32'h000E_0000, 4'b0100);
    cfg_check("R6 smb ctl readback", 8'hD0, 32'h000E_0000);
    io_check("R9 smb disabled", 16'hEF5A, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
    cfg_write(8'hD0, 32'h0001_0000, 4'b0100);
  endtask

  task automatic t_timing;
    // write and access in the same cycle: access sees old base
    cfg_wr = 1'b1; cfg_addr = 8'h90; cfg_wdata = 32'h0000_2000; cfg_be = 4'hF;
    io_valid = 1'b1; io_addr = 16'h2003; io_size = 2'b00;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; io_valid = 1'b0;
    chk("R10 same cycle old base", {31'h0, smb_hit}, 32'h0);
    io_check("R10 next cycle new base", 16'h2003, 2'b00, 1'b0, 7'h0, 1'b1, 4'h3);
    io_check("R10 old base gone", 16'hEF5A, 2'b00, 1'b0, 7'h0, 1'b0, 4'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = 8'h0; cfg_be = 4'h0;
    cfg_wdata = 32'h0; io_valid = 1'b0; io_addr = 16'h0; io_size = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bases();
    t_lanes();
    t_enables();
    t_pm_decode();
    t_smb_decode();
    t_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule